// File: doc/BRIEF.md
# Manchester Line Decoder

This block recovers data bits from a Manchester-coded serial line. The line is sampled once per clock, and the clock runs at twice the data rate, so each data period covers two samples. A data 1 is a low half followed by a high half. A data 0 is a high half followed by a low half. The quiet line rests high. Every packet opens with a data 0, whose leading high half cannot be told apart from the quiet line.

The decoder is a Moore machine. The first high-to-low step out of idle fixes the phase of the data periods. From then on, each pair of samples either yields one bit or ends the packet. A pair of two highs means the line has gone quiet, and the machine returns to idle. A pair of two lows is a coding error, and the machine waits until the line has been high for a set number of consecutive samples before it accepts a new packet. Each recovered bit is shown on the data output for exactly one cycle, qualified by the valid output.

Top module: `manch_line_decoder`

## Requirements
- R1: A synchronous active-low reset puts the decoder in idle with `bit_valid` = 0 and `bit_out` = 0 in the cycle after the reset edge.
- R2: While idle, samples of 1 on `line_in` never raise `bit_valid`.
- R3: In idle, a sample of 0 completes the opening data 0 of a packet. In the next cycle `bit_valid` = 1 and `bit_out` = 0.
- R4: After the opening bit, each pair of consecutive samples (first, second) with first ≠ second is one data period. In the cycle after the second sample, `bit_valid` = 1 and `bit_out` = the second sample: 1 for the pair 0→1 and 0 for the pair 1→0.
- R5: `bit_valid` is high for exactly one cycle per decoded bit. It is low in the cycle after the first sample of a data period, so it is never high in two consecutive cycles.
- R6: A data period whose two samples are both 1 produces no valid bit and returns the decoder to idle. The line therefore never carries three equal high samples inside a packet. The next 0 sample then starts a new packet, as in R3.
- R7: A data period whose two samples are both 0 is an error. No valid bit is produced for it, and the decoder enters the error condition. The line therefore never carries three equal low samples inside a packet.
- R8: In the error condition, `bit_valid` stays low until `REARM_ONES` (default 2) consecutive samples of 1 have been taken. Any 0 sample restarts that count. When the count completes, the decoder is idle, and the next 0 sample starts a packet.
- R9: `bit_out` is 0 in every cycle in which `bit_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock, twice the data rate |
| rst_n | input | 1 | Synchronous reset, active low |
| line_in | input | 1 | Manchester-coded line sample |
| bit_out | output | 1 | Decoded data bit, meaningful while `bit_valid` is high |
| bit_valid | output | 1 | One-cycle strobe marking a newly decoded bit |

## Verification
Packets made only of zeros, only of ones, and of alternating bits show that each decoded value follows the direction of the mid-period transition and not the level of the line or the length of a run. Two kinds of pair end a packet: two highs, which are legal, and two lows, which are an error. The bench drives both and checks that the first leads straight back to idle while the second holds the valid output low. Inside the error condition, broken runs of ones show that the re-arm count starts again after any low sample. A reset in the middle of a packet shows that the phase is dropped and the next packet is decoded from its own start.

// File: rtl/manch_pkg.sv
// Package manch_pkg
// Shared state encoding for the Manchester line decoder.
// Assumes: one sample per clock, two samples per data period.
package manch_pkg;

    // Decoder states; BIT0/BIT1 are the Moore states that present a bit.
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,  // quiet line, waiting for the first low sample
        ST_HALF0 = 3'd1,  // first half of a period captured as 0
        ST_HALF1 = 3'd2,  // first half of a period captured as 1
        ST_BIT0  = 3'd3,  // a data 0 has just been completed
        ST_BIT1  = 3'd4,  // a data 1 has just been completed
        ST_ERR   = 3'd5   // coding error, waiting for a run of ones
    } mstate_t;

endpackage

// File: rtl/manch_rearm_counter.sv
// Module manch_rearm_counter
// Counts consecutive 1 samples while the decoder sits in the error
// condition. It raises rearm_done on the sample that completes the run.
// Assumes: in_err is high for every cycle spent in the error state.
module manch_rearm_counter #(
    parameter int REARM_ONES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_err,
    input  logic line_in,
    output logic rearm_done
);

    localparam int CNT_W = $clog2(REARM_ONES + 1);
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(REARM_ONES - 1);

    logic [CNT_W-1:0] ones_cnt;

    // The run completes when this sample is a 1 and enough earlier ones were seen.
    always_comb begin
        rearm_done = in_err && line_in && (ones_cnt == LAST_CNT);
    end

    // Track the current run of ones; clear outside the error state or on a 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ones_cnt <= '0;
        end else if (!in_err || !line_in || rearm_done) begin
            ones_cnt <= '0;
        end else begin
            ones_cnt <= ones_cnt + 1'b1;
        end
    end

    // R8
    rearm_cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ones_cnt <= LAST_CNT);

    // R8
    rearm_zero_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_err && !line_in) |=> (ones_cnt == '0));

endmodule

// File: rtl/manch_next_state.sv
// Module manch_next_state
// Next-state function of the decoder. It locks the data-period phase on
// the first low sample out of idle and then pairs the samples that follow.
// Assumes: the caller registers the result every clock.
module manch_next_state
    import manch_pkg::*;
(
    input  mstate_t state,
    input  logic    line_in,
    input  logic    rearm_done,
    output mstate_t state_nxt
);

    // Choose the successor state from the current state and the sample.
    always_comb begin
        state_nxt = ST_IDLE;
        unique case (state)
            ST_IDLE:  state_nxt = line_in ? ST_IDLE  : ST_BIT0;
            ST_BIT0,
            ST_BIT1:  state_nxt = line_in ? ST_HALF1 : ST_HALF0;
            ST_HALF0: state_nxt = line_in ? ST_BIT1  : ST_ERR;
            ST_HALF1: state_nxt = line_in ? ST_IDLE  : ST_BIT0;
            ST_ERR:   state_nxt = rearm_done ? ST_IDLE : ST_ERR;
            default:  state_nxt = ST_IDLE;
        endcase
    end

endmodule

// File: rtl/manch_out_decode.sv
// Module manch_out_decode
// Moore output decode: the outputs depend only on the registered state.
// Assumes: only ST_BIT0 and ST_BIT1 stand for a completed bit.
module manch_out_decode
    import manch_pkg::*;
(
    input  mstate_t state,
    output logic    bit_out,
    output logic    bit_valid
);

    // Present the completed bit and its strobe.
    always_comb begin
        bit_valid = (state == ST_BIT0) || (state == ST_BIT1);
        bit_out   = (state == ST_BIT1);
    end

endmodule

// File: rtl/manch_line_decoder.sv
// Module manch_line_decoder (top)
// Recovers data bits from a Manchester line sampled at twice the data rate.
// It returns to idle on a high-high period and enters an error wait on a
// low-low period. It re-arms after REARM_ONES consecutive high samples.
// Assumes: line_in is synchronous to clk; rst_n is synchronous, active low.
module manch_line_decoder
    import manch_pkg::*;
#(
    parameter int REARM_ONES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_in,
    output logic bit_out,
    output logic bit_valid
);

    mstate_t state;
    mstate_t state_nxt;
    logic    rearm_done;
    logic    in_err;

    assign in_err = (state == ST_ERR);

    manch_rearm_counter #(
        .REARM_ONES (REARM_ONES)
    ) u_rearm (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_err     (in_err),
        .line_in    (line_in),
        .rearm_done (rearm_done)
    );

    manch_next_state u_next (
        .state      (state),
        .line_in    (line_in),
        .rearm_done (rearm_done),
        .state_nxt  (state_nxt)
    );

    manch_out_decode u_out (
        .state     (state),
        .bit_out   (bit_out),
        .bit_valid (bit_valid)
    );

    // State register with synchronous reset to idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nxt;
        end
    end

    // Checker-only count of sampling edges since reset, saturating at 2.
    logic [1:0] hist_cnt;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist_cnt <= 2'd0;
        end else if (hist_cnt != 2'd2) begin
            hist_cnt <= hist_cnt + 2'd1;
        end
    end

    // R4
    valid_bit_is_last_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bit_valid |-> (bit_out == $past(line_in)));

    // R4
    valid_needs_transition_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_valid && hist_cnt == 2'd2) |-> ($past(line_in) != $past(line_in, 2)));

    // R5
    valid_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bit_valid |=> !bit_valid);

    // R3
    idle_low_starts_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !line_in) |=> (bit_valid && !bit_out));

    // R6
    high_pair_to_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HALF1 && line_in) |=> (!bit_valid && state == ST_IDLE));

    // R7
    low_pair_to_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HALF0 && !line_in) |=> (!bit_valid && in_err));

    // R8
    err_holds_valid_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_err |=> !bit_valid);

endmodule

// File: tb/manch_line_decoder_bench.sv
// Bench for manch_line_decoder: a behavioural reference model compared
// against the outputs on every clock, plus per-packet bit-list checks.
module manch_line_decoder_bench;

    localparam int REARM = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic line_in = 1'b1;
    logic bit_out;
    logic bit_valid;

    int n_checks = 0;
    int n_fail = 0;
    string cur_req = "R1";

    // Reference model state (behavioural)
    int  m_mode = 0;     // 0 idle, 1 await first half, 2 have first half, 3 error
    int  m_first = 0;
    int  m_ones = 0;
    logic exp_v = 1'b0;
    logic exp_d = 1'b0;

    logic got_q[$];
    logic want_q[$];

    always #5 clk = ~clk;

    manch_line_decoder #(.REARM_ONES(REARM)) u_manch_line_decoder (
        .clk       (clk),
        .rst_n     (rst_n),
        .line_in   (line_in),
        .bit_out   (bit_out),
        .bit_valid (bit_valid)
    );

    task automatic check(input string req, input logic act, input logic exp, input string what);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
        end
    endtask

    // Model one sample: predicts the outputs after the next rising edge.
    task automatic model_step(input logic rst_now, input logic b);
        exp_v = 1'b0;
        exp_d = 1'b0;
        if (!rst_now) begin
            m_mode = 0;
            m_ones = 0;
        end else begin
            case (m_mode)
                0: if (b == 1'b0) begin exp_v = 1'b1; exp_d = 1'b0; m_mode = 1; end
                1: begin m_first = int'(b); m_mode = 2; end
                2: begin
                    if (int'(b) != m_first) begin
                        exp_v = 1'b1; exp_d = b; m_mode = 1;
                    end else if (b) begin
                        m_mode = 0;
                    end else begin
                        m_mode = 3; m_ones = 0;
                    end
                end
                default: begin
                    if (b) begin
                        m_ones++;
                        if (m_ones >= REARM) m_mode = 0;
                    end else begin
                        m_ones = 0;
                    end
                end
            endcase
        end
    endtask

    // Compare the current outputs, then drive the next sample and reset level.
    task automatic drive(input logic rst_lvl, input logic b);
        @(negedge clk);
        check(cur_req, bit_valid, exp_v, "bit_valid");
        check(cur_req, bit_out, exp_d, "bit_out");
        if (bit_valid === 1'b1) got_q.push_back(bit_out);
        rst_n = rst_lvl;
        line_in = b;
        model_step(rst_lvl, b);
    endtask

    task automatic sample(input logic b);
        drive(1'b1, b);
    endtask

    // Packet: bits[0] first (must be 0), then three idle highs; checks the bit list.
    task automatic send_packet(input string req, input logic [15:0] bits, input int n);
        cur_req = req;
        got_q.delete();
        want_q.delete();
        for (int i = 0; i < n; i++) begin
            want_q.push_back(bits[i]);
            sample(~bits[i]);
            sample(bits[i]);
        end
        for (int i = 0; i < 3; i++) sample(1'b1);
        n_checks++;
        if (got_q.size() != want_q.size()) begin
            n_fail++;
            $display("FAIL %s bit count (R5): actual %0d expected %0d", req, got_q.size(), want_q.size());
        end else begin
            for (int i = 0; i < want_q.size(); i++) begin
                check(req, got_q[i], want_q[i], "decoded bit");
            end
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        // R1: reset state
        cur_req = "R1";
        for (int i = 0; i < 3; i++) drive(1'b0, 1'b1);
        @(negedge clk);
        check("R1", bit_valid, 1'b0, "bit_valid in reset");
        check("R1", bit_out, 1'b0, "bit_out in reset");

        // R2: quiet line
        cur_req = "R2";
        for (int i = 0; i < 6; i++) sample(1'b1);

        // R3, R4, R9: several data patterns
        send_packet("R3", 16'b0000_0000_0000_0000, 4);
        send_packet("R4", 16'b0000_0000_0001_1110, 5);
        send_packet("R4", 16'b0000_0000_0010_1010, 6);
        send_packet("R9", 16'b0000_1011_0011_0110, 12);

        // R6: high-high period ends a packet, then a new packet decodes
        cur_req = "R6";
        sample(1'b1); sample(1'b0);           // opening 0
        sample(1'b0); sample(1'b1);           // data 1
        sample(1'b1); sample(1'b1);           // high-high: back to idle
        sample(1'b1);
        send_packet("R6", 16'b0000_0000_0000_0100, 3);

        // R7: low-low period is an error
        cur_req = "R7";
        sample(1'b1); sample(1'b0);           // opening 0
        sample(1'b1); sample(1'b0);           // data 0
        sample(1'b0); sample(1'b0);           // low-low: error
        // R8: broken runs of ones do not re-arm
        cur_req = "R8";
        sample(1'b1); sample(1'b0);
        sample(1'b1); sample(1'b0);
        sample(1'b0); sample(1'b1);
        sample(1'b0);
        sample(1'b1); sample(1'b1);           // two ones: re-armed
        sample(1'b1);
        send_packet("R8", 16'b0000_0000_0000_1010, 4);

        // R8: error entered right at packet start, immediate re-arm
        cur_req = "R8";
        sample(1'b0); sample(1'b0); sample(1'b0);
        sample(1'b1); sample(1'b1);
        sample(1'b0);                         // starts a packet
        sample(1'b0); sample(1'b1);           // data 1
        for (int i = 0; i < 3; i++) sample(1'b1);

        // R1: reset in the middle of a packet
        cur_req = "R1";
        sample(1'b1); sample(1'b0); sample(1'b0);
        drive(1'b0, 1'b1);
        drive(1'b0, 1'b1);
        send_packet("R1", 16'b0000_0000_0011_0010, 6);

        @(negedge clk);
        check("R2", bit_valid, exp_v, "final bit_valid");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule